// File: doc/BRIEF.md
# Store Queue with Load Forwarding Check

This block keeps the stores that a core has issued but not yet written to memory. It holds them in a circular buffer in program order. A store takes a slot when it is dispatched. It receives its address and data later, once it executes. It is marked committed when it retires. The slot at the head leaves the queue to memory only when that store is committed and its address is known, so memory sees the stores in exactly their program order.

A load presents its address together with its queue position. The position is the allocation pointer value captured when the load was dispatched. Only slots from the head up to, but not including, that position count as older than the load. The block compares the load address at full width against every older resolved store. The youngest matching store supplies the forwarded data. If any older store still lacks an address, the load is told to wait.

A flush input moves the allocation pointer back to a given position. This discards the uncommitted stores from that position onward after a misprediction.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_pos` is 0, `mem_valid` is 0, and `ld_hit` and `ld_wait` are 0.
- R2: Each accepted allocation returns the current allocation position on `alloc_pos`, a pointer of IW+1 bits whose top bit is a wrap bit. After the allocation the pointer is one higher, modulo 2*DEPTH. The slot index is the low IW bits of the pointer.
- R3: While DEPTH stores are held, `alloc_ready` is 0 and an `alloc_valid` request has no effect on `alloc_pos`. Draining one store makes `alloc_ready` 1 again.
- R4: A resolve request writes an address and data into the slot named by `res_idx`. A commit request marks the slot named by `cm_idx` as committed.
- R5: A load compares only against slots from the head up to, but excluding, `ld_pos`. Stores at or beyond that position, resolved or not, have no effect on the load result.
- R6: When several older resolved stores match the load address, `ld_hit` is 1 and `ld_data` is the data of the youngest of them.
- R7: When any older store has no address yet, `ld_wait` is 1 and `ld_hit` is 0.
- R8: When no older store matches and none is unresolved, both `ld_hit` and `ld_wait` are 0.
- R9: `mem_valid` is 1 only when the head slot is committed and resolved. It then presents that slot's address and data, and holds them until `mem_ready`, when the head advances by one. A committed younger slot is never presented ahead of an uncommitted head.
- R10: A flush sets the allocation pointer to `flush_pos`, holds `alloc_ready` at 0 in that cycle, and drops every slot from `flush_pos` onward, so later loads see only their reallocated contents.
- R11: Address comparison uses all AW bits. Addresses that differ only in the top bit do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a new store slot |
| alloc_ready | output | 1 | Slot available and no flush this cycle |
| alloc_pos | output | IW+1 | Position given to the allocating store |
| res_valid | input | 1 | Write address and data of a slot |
| res_idx | input | IW | Slot to resolve |
| res_addr | input | AW | Store address |
| res_data | input | DW | Store data |
| cm_valid | input | 1 | Mark a slot committed |
| cm_idx | input | IW | Slot to commit |
| ld_valid | input | 1 | Load lookup request |
| ld_pos | input | IW+1 | Allocation position seen by the load at dispatch |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | Forwarding data available |
| ld_wait | output | 1 | An older store address is unknown |
| ld_data | output | DW | Forwarded data |
| flush_valid | input | 1 | Discard slots from flush_pos onward |
| flush_pos | input | IW+1 | New allocation position |
| mem_valid | output | 1 | Head store ready for memory |
| mem_ready | input | 1 | Memory accepts the head store |
| mem_addr | output | AW | Head store address |
| mem_data | output | DW | Head store data |

## Verification
The case that is hardest to reach is a load whose position lies in the middle of the occupied range. Older and younger slots then hold the same address, and unresolved slots sit on both sides of the position. The bench builds this by allocating several stores, resolving only chosen slots, and issuing loads at several positions against the same queue contents, so that the result depends only on the age window. Flush recovery is reached the same way. Slots are filled with matching addresses, the queue is cut back, and a slot is reallocated. A load must then wait on the reallocated slot instead of forwarding the stale data that the slot held before.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int SQ_DEPTH = 8;
    localparam int SQ_AW    = 32;
    localparam int SQ_DW    = 32;

    typedef enum logic [1:0] {
        LD_MISS = 2'd0,
        LD_HIT  = 2'd1,
        LD_WAIT = 2'd2
    } ld_res_e;
endpackage

// File: rtl/sq_match.sv
module sq_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic [PW-1:0]             head,
    input  logic [PW-1:0]             ld_pos,
    input  logic [AW-1:0]             ld_addr,
    input  logic [DEPTH-1:0]          av,
    input  logic [DEPTH-1:0][AW-1:0]  addr,
    output logic [DEPTH-1:0]          match_age,
    output logic [DEPTH-1:0]          unk_age
);
    logic [PW-1:0] older_cnt;
    assign older_cnt = ld_pos - head;

    // index k of the outputs is the k-th oldest slot
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [IW-1:0] phys;
        logic          older;
        assign phys         = head[IW-1:0] + IW'(k);
        assign older        = PW'(k) < older_cnt;
        assign match_age[k] = older && av[phys] && (addr[phys] == ld_addr);
        assign unk_age[k]   = older && !av[phys];
    end
endmodule

// File: rtl/sq_pick.sv
module sq_pick
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] match_age,
    input  logic [DEPTH-1:0] unk_age,
    output ld_res_e          res,
    output logic [IW-1:0]    sel_off
);
    logic any_match;

    always_comb begin
        any_match = 1'b0;
        sel_off   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match_age[k]) begin
                any_match = 1'b1;
                sel_off   = IW'(k);
            end
        end
        if (|unk_age)       res = LD_WAIT;
        else if (any_match) res = LD_HIT;
        else                res = LD_MISS;
    end
endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = SQ_DEPTH,
    parameter int AW    = SQ_AW,
    parameter int DW    = SQ_DW,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    output logic          alloc_ready,
    output logic [PW-1:0] alloc_pos,
    input  logic          res_valid,
    input  logic [IW-1:0] res_idx,
    input  logic [AW-1:0] res_addr,
    input  logic [DW-1:0] res_data,
    input  logic          cm_valid,
    input  logic [IW-1:0] cm_idx,
    input  logic          ld_valid,
    input  logic [PW-1:0] ld_pos,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic          ld_wait,
    output logic [DW-1:0] ld_data,
    input  logic          flush_valid,
    input  logic [PW-1:0] flush_pos,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data
);
    typedef struct packed {
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [DEPTH-1:0]         av;
        logic [DEPTH-1:0]         cm;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
    } sq_state_t;

    sq_state_t state_d, state_q;

    logic          full, empty, alloc_fire, drain_fire;
    logic [IW-1:0] head_idx, tail_idx, sel_off, sel_idx;
    logic [PW-1:0] head_q;
    logic [DEPTH-1:0] match_age, unk_age;
    ld_res_e       ld_res;

    assign head_q   = state_q.head;
    assign head_idx = state_q.head[IW-1:0];
    assign tail_idx = state_q.tail[IW-1:0];
    assign empty    = state_q.head == state_q.tail;
    assign full     = (state_q.head[IW-1:0] == state_q.tail[IW-1:0]) &&
                      (state_q.head[IW] != state_q.tail[IW]);

    assign alloc_ready = !full && !flush_valid;
    assign alloc_pos   = state_q.tail;
    assign alloc_fire  = alloc_valid && alloc_ready;

    assign mem_valid  = !empty && state_q.av[head_idx] && state_q.cm[head_idx];
    assign mem_addr   = state_q.addr[head_idx];
    assign mem_data   = state_q.data[head_idx];
    assign drain_fire = mem_valid && mem_ready;

    sq_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
        .head      (state_q.head),
        .ld_pos    (ld_pos),
        .ld_addr   (ld_addr),
        .av        (state_q.av),
        .addr      (state_q.addr),
        .match_age (match_age),
        .unk_age   (unk_age)
    );

    sq_pick #(.DEPTH(DEPTH)) u_pick (
        .match_age (match_age),
        .unk_age   (unk_age),
        .res       (ld_res),
        .sel_off   (sel_off)
    );

    assign sel_idx = head_idx + sel_off;
    assign ld_hit  = ld_valid && (ld_res == LD_HIT);
    assign ld_wait = ld_valid && (ld_res == LD_WAIT);
    assign ld_data = state_q.data[sel_idx];

    always_comb begin
        state_d = state_q;
        if (res_valid) begin
            state_d.av[res_idx]   = 1'b1;
            state_d.addr[res_idx] = res_addr;
            state_d.data[res_idx] = res_data;
        end
        if (cm_valid) begin
            state_d.cm[cm_idx] = 1'b1;
        end
        if (drain_fire) begin
            state_d.av[head_idx] = 1'b0;
            state_d.cm[head_idx] = 1'b0;
            state_d.head         = state_q.head + PW'(1);
        end
        if (flush_valid) begin
            state_d.tail = flush_pos;
        end else if (alloc_fire) begin
            state_d.av[tail_idx] = 1'b0;
            state_d.cm[tail_idx] = 1'b0;
            state_d.tail         = state_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic [PW-1:0] alloc_pos,
    input logic [PW-1:0] head_q,
    input logic          ld_hit,
    input logic          ld_wait,
    input logic          flush_valid,
    input logic [PW-1:0] flush_pos,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data
);
    logic [PW-1:0] occ;
    assign occ = alloc_pos - head_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R3

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == PW'(DEPTH)) |-> !alloc_ready); // R3

    AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |=> (alloc_pos == $past(alloc_pos) + PW'(1))); // R2

    AST_WAIT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wait |-> !ld_hit); // R7

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R9

    AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (alloc_pos == $past(flush_pos))); // R10
endmodule

bind store_queue store_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_pos   (alloc_pos),
    .head_q      (head_q),
    .ld_hit      (ld_hit),
    .ld_wait     (ld_wait),
    .flush_valid (flush_valid),
    .flush_pos   (flush_pos),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data)
);

// File: tb/store_queue_tb.sv
module store_queue_tb;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int IW    = 3;
    localparam int PW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic          alloc_ready;
    logic [PW-1:0] alloc_pos;
    logic          res_valid = 1'b0;
    logic [IW-1:0] res_idx = '0;
    logic [AW-1:0] res_addr = '0;
    logic [DW-1:0] res_data = '0;
    logic          cm_valid = 1'b0;
    logic [IW-1:0] cm_idx = '0;
    logic          ld_valid = 1'b0;
    logic [PW-1:0] ld_pos = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_hit, ld_wait;
    logic [DW-1:0] ld_data;
    logic          flush_valid = 1'b0;
    logic [PW-1:0] flush_pos = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int checks = 0;
    int errors = 0;

    localparam logic [AW-1:0] A = 32'h0000_1000;
    localparam logic [AW-1:0] B = 32'h0000_2000;
    localparam logic [AW-1:0] C = 32'h0000_3000;

    always #5 clk = ~clk;

    store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        alloc_valid = 0; res_valid = 0; cm_valid = 0; ld_valid = 0;
        flush_valid = 0; mem_ready = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic do_alloc(output logic [PW-1:0] p);
        alloc_valid = 1'b1;
        #1 p = alloc_pos;
        @(posedge clk);
        #1 alloc_valid = 1'b0;
    endtask

    task automatic do_resolve(input logic [IW-1:0] i, input logic [AW-1:0] a, input logic [DW-1:0] d);
        res_valid = 1'b1; res_idx = i; res_addr = a; res_data = d;
        @(posedge clk);
        #1 res_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [IW-1:0] i);
        cm_valid = 1'b1; cm_idx = i;
        @(posedge clk);
        #1 cm_valid = 1'b0;
    endtask

    task automatic load_chk(input string req, input logic [PW-1:0] pos, input logic [AW-1:0] a,
                            input logic eh, input logic ew, input logic [DW-1:0] ed);
        ld_valid = 1'b1; ld_pos = pos; ld_addr = a;
        #1;
        check({req, " hit"}, 64'(ld_hit), 64'(eh));
        check({req, " wait"}, 64'(ld_wait), 64'(ew));
        if (eh) check({req, " data"}, 64'(ld_data), 64'(ed));
        ld_valid = 1'b0;
        #1;
    endtask

    task automatic test_reset();
        apply_reset();
        ld_valid = 1'b1; ld_pos = '0; ld_addr = A;
        #1;
        check("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        check("R1 alloc_pos", 64'(alloc_pos), 64'd0);
        check("R1 mem_valid", 64'(mem_valid), 64'd0);
        check("R1 ld_hit", 64'(ld_hit), 64'd0);
        check("R1 ld_wait", 64'(ld_wait), 64'd0);
        ld_valid = 1'b0;
    endtask

    task automatic test_forward();
        logic [PW-1:0] p;
        apply_reset();
        for (int i = 0; i < 3; i++) begin
            do_alloc(p);
            check("R2 alloc order", 64'(p), 64'(i));
        end
        do_resolve(0, A, 32'hD0);
        do_resolve(1, B, 32'hD1);
        do_resolve(2, A, 32'hD2);
        load_chk("R6 youngest", 4'd3, A, 1, 0, 32'hD2);
        load_chk("R5 window", 4'd2, A, 1, 0, 32'hD0);
        load_chk("R5 none older", 4'd0, A, 0, 0, '0);
        load_chk("R8 miss", 4'd3, C, 0, 0, '0);
        load_chk("R11 top bit", 4'd3, A ^ 32'h8000_0000, 0, 0, '0);
        load_chk("R4 resolve B", 4'd3, B, 1, 0, 32'hD1);
    endtask

    task automatic test_wait();
        logic [PW-1:0] p;
        apply_reset();
        do_alloc(p);
        do_alloc(p);
        do_resolve(0, A, 32'hE0);
        load_chk("R5 younger unresolved", 4'd1, A, 1, 0, 32'hE0);
        load_chk("R7 older unresolved", 4'd2, A, 0, 1, '0);
        load_chk("R7 unrelated addr", 4'd2, C, 0, 1, '0);
    endtask

    task automatic test_drain();
        logic [PW-1:0] p;
        apply_reset();
        for (int i = 0; i < 3; i++) do_alloc(p);
        do_resolve(0, A, 32'hA0);
        do_resolve(1, B, 32'hA1);
        do_resolve(2, C, 32'hA2);
        do_commit(1);
        check("R9 head not committed", 64'(mem_valid), 64'd0);
        do_commit(0);
        check("R9 head valid", 64'(mem_valid), 64'd1);
        check("R9 head addr", 64'(mem_addr), 64'(A));
        mem_ready = 1'b1;
        @(posedge clk);
        #1 mem_ready = 1'b0;
        check("R9 next valid", 64'(mem_valid), 64'd1);
        check("R9 next addr", 64'(mem_addr), 64'(B));
        check("R9 next data", 64'(mem_data), 64'hA1);
        @(posedge clk);
        #1;
        check("R9 held addr", 64'(mem_addr), 64'(B));
        mem_ready = 1'b1;
        @(posedge clk);
        #1 mem_ready = 1'b0;
        check("R9 uncommitted head", 64'(mem_valid), 64'd0);
    endtask

    task automatic test_full();
        logic [PW-1:0] p;
        apply_reset();
        for (int i = 0; i < DEPTH; i++) do_alloc(p);
        check("R3 full ready", 64'(alloc_ready), 64'd0);
        check("R3 full pos", 64'(alloc_pos), 64'd8);
        alloc_valid = 1'b1;
        @(posedge clk);
        #1 alloc_valid = 1'b0;
        check("R3 ignored alloc", 64'(alloc_pos), 64'd8);
        do_resolve(0, A, 32'h55);
        do_commit(0);
        mem_ready = 1'b1;
        @(posedge clk);
        #1 mem_ready = 1'b0;
        check("R3 ready after drain", 64'(alloc_ready), 64'd1);
        do_alloc(p);
        check("R2 wrap bit", 64'(p), 64'd8);
    endtask

    task automatic test_flush();
        logic [PW-1:0] p;
        apply_reset();
        for (int i = 0; i < 4; i++) do_alloc(p);
        do_resolve(0, A, 32'h10);
        do_resolve(1, A, 32'h11);
        do_resolve(2, A, 32'h12);
        do_resolve(3, B, 32'h13);
        flush_valid = 1'b1; flush_pos = 4'd2; alloc_valid = 1'b1;
        #1;
        check("R10 ready in flush", 64'(alloc_ready), 64'd0);
        @(posedge clk);
        #1 flush_valid = 1'b0; alloc_valid = 1'b0;
        check("R10 new pos", 64'(alloc_pos), 64'd2);
        do_alloc(p);
        check("R10 realloc pos", 64'(p), 64'd2);
        load_chk("R10 stale dropped", 4'd3, A, 0, 1, '0);
        do_resolve(2, C, 32'h20);
        load_chk("R10 survivor", 4'd3, A, 1, 0, 32'h11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_forward();
        test_wait();
        test_drain();
        test_full();
        test_flush();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule